// File: doc/BRIEF.md
# Two-Port Byte-Lane Memory

This block is a synchronous 2048 x 16 storage array with two independent access ports, called left and right. Each port carries its own address, an active-low enable, an active-low read enable, two active-low byte write strobes, write data and a 16-bit read-data output with one valid bit per byte lane. Either port may read or write any location at any time, independently of the other port.

A single access may write one byte lane and read the other. Writes land on the rising clock edge. Read data is registered and appears one cycle after the access is presented. Each port also has an active-low hold input, driven by an external arbiter. While hold is low, that port's writes are silently dropped and its reads still work. When both ports are disabled, a registered standby flag rises. The design resolves a same-cycle, same-address write from both ports in favour of the left port, lane by lane.

Top module: `dpram_lanes`

## Requirements
- R1: Every one of the 2048 addresses holds a 16-bit word. A word written through either port is read back unchanged through either port.
- R2: While a port's enable is high, that port changes no memory location and its read-valid bits stay 00, whatever its strobes, read enable and data are.
- R3: Write strobe bit 0 (low-active) writes data bits 7:0 and strobe bit 1 writes bits 15:8. Both low writes the whole word. A lane whose strobe is high keeps its stored value.
- R4: In an access with one strobe low and the other high, the strobed lane is stored. If read enable is low, the other lane shows its stored contents, and the written lane's valid bit is low.
- R5: Valid bit b (bit 0 for bits 7:0, bit 1 for bits 15:8) is high in the cycle after an access with enable low, read enable low and strobe b high. Otherwise it is low, and that lane's read data reads as zero.
- R6: While a port's hold input is low, its writes change no memory location. Its reads and valid bits behave as if hold were high.
- R7: Read data comes one cycle after the access is presented. It shows the location's contents from before any write on that same clock edge, including a write from the other port.
- R8: When both ports write the same lane of the same address on the same edge, with neither port held, the left port's byte is stored.
- R9: The standby output is high in the cycle after a cycle in which both enables are high, and low otherwise.
- R10: Right after reset, both valid vectors are 00, both read-data outputs are zero and standby is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| lt_addr | input | ADDR_W (11) | Left word address |
| lt_en_n | input | 1 | Left port enable, active low |
| lt_oe_n | input | 1 | Left read enable, active low |
| lt_wr_n | input | LANES (2) | Left byte write strobes, active low, bit 0 = bits 7:0 |
| lt_hold_n | input | 1 | Left write inhibit, active low |
| lt_wdata | input | LANES*LANE_W (16) | Left write data |
| lt_rdata | output | LANES*LANE_W (16) | Left read data, zero on lanes not valid |
| lt_rvalid | output | LANES (2) | Left per-lane read valid |
| rt_addr | input | ADDR_W (11) | Right word address |
| rt_en_n | input | 1 | Right port enable, active low |
| rt_oe_n | input | 1 | Right read enable, active low |
| rt_wr_n | input | LANES (2) | Right byte write strobes, active low, bit 0 = bits 7:0 |
| rt_hold_n | input | 1 | Right write inhibit, active low |
| rt_wdata | input | LANES*LANE_W (16) | Right write data |
| rt_rdata | output | LANES*LANE_W (16) | Right read data, zero on lanes not valid |
| rt_rvalid | output | LANES (2) | Right per-lane read valid |
| standby | output | 1 | Both ports disabled in the previous cycle |

## Verification
Every result of this block is due exactly one edge after its access: read data, lane valid bits and standby all come from registers loaded on the edge that samples the access. Writes are visible to a read presented on the following cycle, not the same one.

The bench applies each access at the falling edge and, at the same moment, queues its expected valid bits, data and standby from a bench-side memory model. The model is read before that access's writes are applied, and it applies the right port's writes before the left port's. A monitor pops one queued item five nanoseconds after each rising edge, so every comparison lands on the single cycle in which the result is due.

// File: rtl/dpr_pkg.sv
package dpr_pkg;

  // Port identifiers used to index per-port arrays inside the top module.
  localparam int PORT_LEFT  = 0;
  localparam int PORT_RIGHT = 1;
  localparam int PORTS      = 2;

  // Control pins of one port that do not depend on lane count or width.
  typedef struct packed {
    logic en_n;    // port enable, active low
    logic oe_n;    // read enable, active low
    logic hold_n;  // write inhibit, active low
  } port_ctl_t;

endpackage

// File: rtl/dpr_port_decode.sv
module dpr_port_decode #(
  parameter int LANES = 2
) (
  input  dpr_pkg::port_ctl_t ctl,
  input  logic [LANES-1:0]   wr_n,
  output logic [LANES-1:0]   lane_we,
  output logic [LANES-1:0]   lane_show,
  output logic               port_off
);

  logic selected;
  logic may_write;
  logic may_read;

  always_comb begin
    selected  = ~ctl.en_n;
    may_write = selected & ctl.hold_n;
    may_read  = selected & ~ctl.oe_n;
    port_off  = ctl.en_n;
  end

  // A lane is written when its strobe is low, and shown when its strobe is high.
  for (genvar b = 0; b < LANES; b++) begin : g_lane
    always_comb begin
      lane_we[b]   = may_write & ~wr_n[b];
      lane_show[b] = may_read & wr_n[b];
    end
  end

endmodule

// File: rtl/dpr_lane_bank.sv
module dpr_lane_bank #(
  parameter int ADDR_W = 11,
  parameter int LANE_W = 8
) (
  input  logic              clk,
  input  logic              a_we,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic [LANE_W-1:0] a_wd,
  output logic [LANE_W-1:0] a_rd,
  input  logic              b_we,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic [LANE_W-1:0] b_wd,
  output logic [LANE_W-1:0] b_rd
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [LANE_W-1:0] mem [DEPTH];

  // Read-first on both ports. Port a (left) is assigned last, so it wins a
  // same-address collision.
  always_ff @(posedge clk) begin
    a_rd <= mem[a_addr];
    b_rd <= mem[b_addr];
    if (b_we) mem[b_addr] <= b_wd;
    if (a_we) mem[a_addr] <= a_wd;
  end

endmodule

// File: rtl/dpr_read_stage.sv
module dpr_read_stage #(
  parameter int LANES  = 2,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [LANES-1:0]        lane_show,
  input  logic [LANES*LANE_W-1:0] raw_rd,
  output logic [LANES*LANE_W-1:0] rdata,
  output logic [LANES-1:0]        rvalid
);

  logic [LANES-1:0] show_q;

  always_ff @(posedge clk) begin
    if (rst) show_q <= '0;
    else     show_q <= lane_show;
  end

  assign rvalid = show_q;

  // Lanes that are not shown read as zero.
  for (genvar b = 0; b < LANES; b++) begin : g_gate
    assign rdata[b*LANE_W +: LANE_W] =
      show_q[b] ? raw_rd[b*LANE_W +: LANE_W] : '0;
  end

endmodule

// File: rtl/dpram_lanes.sv
module dpram_lanes #(
  parameter int ADDR_W = 11,
  parameter int LANE_W = 8,
  parameter int LANES  = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic [ADDR_W-1:0]       lt_addr,
  input  logic                    lt_en_n,
  input  logic                    lt_oe_n,
  input  logic [LANES-1:0]        lt_wr_n,
  input  logic                    lt_hold_n,
  input  logic [LANES*LANE_W-1:0] lt_wdata,
  output logic [LANES*LANE_W-1:0] lt_rdata,
  output logic [LANES-1:0]        lt_rvalid,
  input  logic [ADDR_W-1:0]       rt_addr,
  input  logic                    rt_en_n,
  input  logic                    rt_oe_n,
  input  logic [LANES-1:0]        rt_wr_n,
  input  logic                    rt_hold_n,
  input  logic [LANES*LANE_W-1:0] rt_wdata,
  output logic [LANES*LANE_W-1:0] rt_rdata,
  output logic [LANES-1:0]        rt_rvalid,
  output logic                    standby
);

  import dpr_pkg::*;

  localparam int DATA_W = LANES * LANE_W;

  // Per-port views, indexed by PORT_LEFT / PORT_RIGHT.
  port_ctl_t         ctl      [PORTS];
  logic [LANES-1:0]  wr_n     [PORTS];
  logic [LANES-1:0]  lane_we  [PORTS];
  logic [LANES-1:0]  lane_show[PORTS];
  logic              port_off [PORTS];
  logic [DATA_W-1:0] raw_rd   [PORTS];

  always_comb begin
    ctl[PORT_LEFT]   = '{en_n: lt_en_n, oe_n: lt_oe_n, hold_n: lt_hold_n};
    ctl[PORT_RIGHT]  = '{en_n: rt_en_n, oe_n: rt_oe_n, hold_n: rt_hold_n};
    wr_n[PORT_LEFT]  = lt_wr_n;
    wr_n[PORT_RIGHT] = rt_wr_n;
  end

  for (genvar p = 0; p < PORTS; p++) begin : g_port
    dpr_port_decode #(.LANES(LANES)) u_dec (
      .ctl      (ctl[p]),
      .wr_n     (wr_n[p]),
      .lane_we  (lane_we[p]),
      .lane_show(lane_show[p]),
      .port_off (port_off[p])
    );
  end

  // One storage bank per byte lane, so a lane can be written alone.
  for (genvar b = 0; b < LANES; b++) begin : g_bank
    dpr_lane_bank #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_bank (
      .clk   (clk),
      .a_we  (lane_we[PORT_LEFT][b]),
      .a_addr(lt_addr),
      .a_wd  (lt_wdata[b*LANE_W +: LANE_W]),
      .a_rd  (raw_rd[PORT_LEFT][b*LANE_W +: LANE_W]),
      .b_we  (lane_we[PORT_RIGHT][b]),
      .b_addr(rt_addr),
      .b_wd  (rt_wdata[b*LANE_W +: LANE_W]),
      .b_rd  (raw_rd[PORT_RIGHT][b*LANE_W +: LANE_W])
    );
  end

  dpr_read_stage #(.LANES(LANES), .LANE_W(LANE_W)) u_lt_out (
    .clk      (clk),
    .rst      (rst),
    .lane_show(lane_show[PORT_LEFT]),
    .raw_rd   (raw_rd[PORT_LEFT]),
    .rdata    (lt_rdata),
    .rvalid   (lt_rvalid)
  );

  dpr_read_stage #(.LANES(LANES), .LANE_W(LANE_W)) u_rt_out (
    .clk      (clk),
    .rst      (rst),
    .lane_show(lane_show[PORT_RIGHT]),
    .raw_rd   (raw_rd[PORT_RIGHT]),
    .rdata    (rt_rdata),
    .rvalid   (rt_rvalid)
  );

  always_ff @(posedge clk) begin
    if (rst) standby <= 1'b0;
    else     standby <= port_off[PORT_LEFT] & port_off[PORT_RIGHT];
  end

endmodule

// File: rtl/dpr_checker.sv
module dpr_checker #(
  parameter int LANES = 2
) (
  input logic             clk,
  input logic             rst,
  input logic             lt_en_n,
  input logic             lt_oe_n,
  input logic [LANES-1:0] lt_wr_n,
  input logic [LANES-1:0] lt_rvalid,
  input logic             rt_en_n,
  input logic [LANES-1:0] rt_rvalid,
  input logic             standby
);

  // Set one edge after reset ends, so $past never reaches into reset.
  logic past_ok;
  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  AST_LT_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(lt_en_n)) |-> (lt_rvalid == '0)); // R2

  AST_RT_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(rt_en_n)) |-> (rt_rvalid == '0)); // R2

  AST_LT_LO_SHOWN: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(!lt_en_n && !lt_oe_n && lt_wr_n[0])) |-> lt_rvalid[0]); // R5

  AST_LT_WRITTEN_HIDDEN: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(!lt_en_n && !lt_wr_n[LANES-1])) |-> !lt_rvalid[LANES-1]); // R4

  AST_STANDBY_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> (standby == $past(lt_en_n && rt_en_n))); // R9

endmodule

bind dpram_lanes dpr_checker #(.LANES(LANES)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .lt_en_n  (lt_en_n),
  .lt_oe_n  (lt_oe_n),
  .lt_wr_n  (lt_wr_n),
  .lt_rvalid(lt_rvalid),
  .rt_en_n  (rt_en_n),
  .rt_rvalid(rt_rvalid),
  .standby  (standby)
);

// File: tb/tb_dpram_lanes.sv
`timescale 1ns/1ps
module tb_dpram_lanes;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;   // 50 MHz

  logic [10:0] lt_addr, rt_addr;
  logic        lt_en_n, lt_oe_n, lt_hold_n, rt_en_n, rt_oe_n, rt_hold_n;
  logic [1:0]  lt_wr_n, rt_wr_n, lt_rvalid, rt_rvalid;
  logic [15:0] lt_wdata, rt_wdata, lt_rdata, rt_rdata;
  logic        standby;

  dpram_lanes dut (
    .clk(clk), .rst(rst),
    .lt_addr(lt_addr), .lt_en_n(lt_en_n), .lt_oe_n(lt_oe_n), .lt_wr_n(lt_wr_n),
    .lt_hold_n(lt_hold_n), .lt_wdata(lt_wdata), .lt_rdata(lt_rdata), .lt_rvalid(lt_rvalid),
    .rt_addr(rt_addr), .rt_en_n(rt_en_n), .rt_oe_n(rt_oe_n), .rt_wr_n(rt_wr_n),
    .rt_hold_n(rt_hold_n), .rt_wdata(rt_wdata), .rt_rdata(rt_rdata), .rt_rvalid(rt_rvalid),
    .standby(standby)
  );

  typedef struct {
    logic        en_n, oe_n, hold_n;
    logic [1:0]  wr_n;
    logic [10:0] addr;
    logic [15:0] wd;
  } pin_t;

  typedef struct {
    logic [1:0]  lv, rv;
    logic [15:0] ld, rd;
    logic        sb;
    string       tag;
  } exp_t;

  exp_t        sb_q[$];
  logic [15:0] model [2048];
  int          n_chk = 0;
  int          n_fail = 0;
  bit          done = 0;

  task automatic chk(string tag, string what, logic [15:0] act, logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic pin_t idle();
    pin_t p;
    p.en_n = 1; p.oe_n = 1; p.hold_n = 1; p.wr_n = 2'b11; p.addr = '0; p.wd = '0;
    return p;
  endfunction

  function automatic pin_t wr(logic [10:0] a, logic [15:0] d, logic [1:0] s = 2'b00,
                              logic hold_n = 1, logic oe_n = 1);
    pin_t p;
    p.en_n = 0; p.oe_n = oe_n; p.hold_n = hold_n; p.wr_n = s; p.addr = a; p.wd = d;
    return p;
  endfunction

  function automatic pin_t rd(logic [10:0] a);
    pin_t p;
    p.en_n = 0; p.oe_n = 0; p.hold_n = 1; p.wr_n = 2'b11; p.addr = a; p.wd = '0;
    return p;
  endfunction

  function automatic logic [1:0] vis(pin_t p);
    logic [1:0] v;
    for (int b = 0; b < 2; b++) v[b] = !p.en_n && !p.oe_n && p.wr_n[b];
    return v;
  endfunction

  function automatic logic [15:0] shown(pin_t p, logic [1:0] v);
    logic [15:0] m;
    m = model[p.addr];
    if (!v[0]) m[7:0]  = '0;
    if (!v[1]) m[15:8] = '0;
    return m;
  endfunction

  task automatic commit(pin_t p);
    if (!p.en_n && p.hold_n) begin
      if (!p.wr_n[0]) model[p.addr][7:0]  = p.wd[7:0];
      if (!p.wr_n[1]) model[p.addr][15:8] = p.wd[15:8];
    end
  endtask

  // Driver: apply at the falling edge, queue the result due after the next rising edge.
  task automatic step(pin_t L, pin_t R, string tag);
    exp_t e;
    lt_addr = L.addr; lt_en_n = L.en_n; lt_oe_n = L.oe_n; lt_wr_n = L.wr_n;
    lt_hold_n = L.hold_n; lt_wdata = L.wd;
    rt_addr = R.addr; rt_en_n = R.en_n; rt_oe_n = R.oe_n; rt_wr_n = R.wr_n;
    rt_hold_n = R.hold_n; rt_wdata = R.wd;
    e.lv = vis(L); e.ld = shown(L, e.lv);
    e.rv = vis(R); e.rd = shown(R, e.rv);
    e.sb = L.en_n & R.en_n;
    e.tag = tag;
    sb_q.push_back(e);
    commit(R);   // right first, left overrides on collision
    commit(L);
    @(negedge clk);
  endtask

  // Monitor: compare one item a quarter period after each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (sb_q.size() > 0) begin
        exp_t e;
        e = sb_q.pop_front();
        chk(e.tag, "lt_rvalid", {14'd0, lt_rvalid}, {14'd0, e.lv});
        chk(e.tag, "lt_rdata", lt_rdata, e.ld);
        chk(e.tag, "rt_rvalid", {14'd0, rt_rvalid}, {14'd0, e.rv});
        chk(e.tag, "rt_rdata", rt_rdata, e.rd);
        chk(e.tag, "standby", {15'd0, standby}, {15'd0, e.sb});
      end
    end
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    pin_t p;
    p = idle();
    lt_addr = '0; lt_en_n = 1; lt_oe_n = 1; lt_wr_n = 2'b11; lt_hold_n = 1; lt_wdata = '0;
    rt_addr = '0; rt_en_n = 1; rt_oe_n = 1; rt_wr_n = 2'b11; rt_hold_n = 1; rt_wdata = '0;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R10: reset state before any access
    chk("R10", "lt_rvalid", {14'd0, lt_rvalid}, 16'd0);
    chk("R10", "lt_rdata", lt_rdata, 16'd0);
    chk("R10", "rt_rvalid", {14'd0, rt_rvalid}, 16'd0);
    chk("R10", "rt_rdata", rt_rdata, 16'd0);
    chk("R10", "standby", {15'd0, standby}, 16'd0);

    // R1: fill low addresses and the extremes through both ports
    for (int i = 0; i < 16; i++)
      step(wr(11'(i), 16'(16'h1000 + i * 16'h0111)), idle(), "R1");
    step(wr(11'd2047, 16'hBEEF), wr(11'd1000, 16'h0F0F), "R1");
    step(rd(11'd1000), rd(11'd2047), "R1");
    step(rd(11'd3), rd(11'd3), "R1");

    // R3: single-lane writes keep the other lane
    step(wr(11'd5, 16'hAA11, 2'b10), wr(11'd6, 16'h22BB, 2'b01), "R3");
    step(rd(11'd6), rd(11'd5), "R3");

    // R4: write lower lane, read upper lane in one access
    step(wr(11'd7, 16'h00C4, 2'b10, 1, 0), idle(), "R4");
    step(idle(), wr(11'd8, 16'hD400, 2'b01, 1, 0), "R4");
    step(rd(11'd8), rd(11'd7), "R4");

    // R5: read enable high shows nothing
    p = rd(11'd9); p.oe_n = 1;
    step(p, p, "R5");

    // R2: disabled port with strobes low writes nothing and shows nothing
    p = wr(11'd10, 16'hDEAD, 2'b00, 1, 0); p.en_n = 1;
    step(p, p, "R2");
    step(rd(11'd10), idle(), "R2");

    // R6: hold blocks writes but not reads
    step(wr(11'd11, 16'h6666, 2'b00, 0), idle(), "R6");
    step(idle(), wr(11'd12, 16'h6767, 2'b01, 0, 0), "R6");
    step(rd(11'd11), rd(11'd12), "R6");

    // R7: same-edge write from one port, read from the other gives old data
    step(wr(11'd13, 16'h7777), rd(11'd13), "R7");
    step(rd(11'd14), wr(11'd14, 16'h7171), "R7");
    step(rd(11'd14), rd(11'd13), "R7");

    // R8: both ports write the same address on one edge
    step(wr(11'd15, 16'h8181), wr(11'd15, 16'h1818), "R8");
    step(wr(11'd4, 16'h00A8, 2'b10), wr(11'd4, 16'hB8B8, 2'b00), "R8");
    step(rd(11'd15), rd(11'd4), "R8");

    // R9: standby needs both ports off
    step(idle(), idle(), "R9");
    step(idle(), rd(11'd1), "R9");
    step(rd(11'd2), idle(), "R9");

    // R1: mixed traffic over the pre-filled range
    for (int i = 0; i < 80; i++) begin
      pin_t l, r;
      logic [15:0] d;
      d = 16'(i * 16'h1357) ^ 16'hA5C3;
      case (i % 4)
        0: l = wr(11'(i * 7 % 16), d);
        1: l = wr(11'(i * 7 % 16), d, 2'b10, 1, 0);
        2: l = rd(11'(i * 7 % 16));
        default: l = wr(11'(i * 7 % 16), d, 2'b01, i % 8 == 3 ? 1'b0 : 1'b1, 0);
      endcase
      case (i % 3)
        0: r = rd(11'((i * 5 + 3) % 16));
        1: r = wr(11'((i * 5 + 3) % 16), ~d, 2'b01, 1, 0);
        default: r = wr(11'((i * 5 + 3) % 16), d ^ 16'h0FF0);
      endcase
      step(l, r, "R1");
    end

    step(idle(), idle(), "R9");
    step(idle(), idle(), "R9");
    while (sb_q.size() > 0) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule